// File: doc/BRIEF.md
# Semaphore-Driven Descriptor Chain Sequencer

This block is the command engine of one DMA channel. Software sets a next-command address and then writes a count into the channel semaphore. A nonzero write to an idle channel starts it. The engine reads a three-word descriptor over a simple read port and hands the command word and buffer address to a peripheral execute port. When the peripheral acknowledges, the command is finished. The engine then decrements the semaphore if the command asks for it, and either follows the chain link to the next descriptor or stops.

The semaphore counts commands that are still outstanding. A write adds to the current count, so software can top it up while the channel runs and extend a live chain. Software can also restart a stopped channel from where it paused. A channel reset input aborts the channel at once. The data path of each transfer sits outside this block. The peripheral stands in for it with a request/acknowledge handshake.

Top module: `dsc_chain_seq`

## Requirements
- R1: After `rst_ni` is released the channel is idle: `busy_o`, `cmd_done_o`, `mem_req_o` and `exe_req_o` are 0, and `sema_o` and `nxt_addr_o` are 0.
- R2: A semaphore write (`sema_we_i`) adds `sema_val_i` to the current count. The count is always visible on `sema_o`, one cycle after the write.
- R3: A semaphore write with a nonzero value to an idle channel starts a fetch from the address in `nxt_addr_o` on the next cycle. A write of zero does not start the channel.
- R4: A descriptor is three 32-bit words, requested in this order at base, base+4 and base+8: next address, command word, buffer address. `mem_req_o` and `mem_addr_o` hold until `mem_valid_i` returns the word. In the command word, bit 2 is chain and bit 6 is decrement.
- R5: After a fetch, `exe_req_o` holds with `exe_cmd_o` and `exe_buf_o` until `exe_ack_i`. The acknowledge cycle finishes the command, and `cmd_done_o` pulses for exactly one cycle on the next cycle, whether or not the command decrements.
- R6: A finished command decrements the semaphore only when its bit 6 is set.
- R7: When a finished command has chain set, `nxt_addr_o` takes its next-address word. If the semaphore is then still nonzero, the descriptor at that address is fetched next.
- R8: A finished command without chain returns the channel to idle, even when the semaphore is still nonzero.
- R9: A command that leaves the semaphore at zero returns the channel to idle.
- R10: A semaphore write while busy extends the run. A write in the same cycle as a decrement gives the old count plus the value minus one.
- R11: A write to `nxt_addr_i` while the channel is busy is ignored.
- R12: `chan_rst_i` aborts the channel on the next cycle: idle, semaphore 0, no requests, and no further `cmd_done_o`. It overrides a semaphore write in the same cycle.
- R13: A channel stopped by R9 restarts on a new nonzero semaphore write. It fetches from the address stored by R7, without a new address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_rst_i | input | 1 | Channel abort and clear |
| nxt_we_i | input | 1 | Next-command address write strobe |
| nxt_addr_i | input | ADDR_W | Next-command address to write |
| sema_we_i | input | 1 | Semaphore add strobe |
| sema_val_i | input | SEMA_W | Value added to the semaphore |
| sema_o | output | SEMA_W | Current semaphore count |
| nxt_addr_o | output | ADDR_W | Current next-command address |
| busy_o | output | 1 | Channel is fetching or executing |
| cmd_done_o | output | 1 | One-cycle command-complete pulse |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | ADDR_W | Descriptor word byte address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| exe_req_o | output | 1 | Execute request to peripheral |
| exe_cmd_o | output | 32 | Command word of current descriptor |
| exe_buf_o | output | 32 | Buffer address of current descriptor |
| exe_ack_i | input | 1 | Peripheral finished the command |

## Verification
On every cycle, the assertions check these rules: the semaphore never decrements from zero, fetch and execute requests hold until answered, the completion pulse lasts one cycle, the channel is idle whenever a completion leaves the count at zero, the next-command address is frozen during a fetch, and a channel reset leaves the channel idle and cleared. Some behaviour only the bench scenarios can show. These cover the chain walk over several descriptor layouts and the stored address after a chain ends. They also cover a count that remains when the chain ends, the restart from a paused chain, a top-up during a run, and a top-up that lands in the same cycle as a decrement.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DESC_WORDS = 3;
  localparam int W_NEXT     = 0;
  localparam int W_CMD      = 1;
  localparam int W_BUF      = 2;
  localparam int CHAIN_BIT  = 2;
  localparam int DEC_BIT    = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dsc_sema.sv
module dsc_sema #(
  parameter int SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [SEMA_W-1:0] add_val_i,
  input  logic              dec_i,
  output logic [SEMA_W-1:0] cnt_o,
  output logic [SEMA_W-1:0] cnt_next_o
);
  logic [SEMA_W-1:0] cnt_q;
  logic [SEMA_W-1:0] add_term;

  assign add_term   = add_i ? add_val_i : '0;
  assign cnt_next_o = clr_i ? '0 : (cnt_q + add_term - SEMA_W'(dec_i));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end

  // a decrement only ever lands on a live count
  p_sema_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i) |-> (cnt_q != '0 || (add_i && add_val_i != '0)));
endmodule

// File: rtl/dsc_fetch.sv
module dsc_fetch
  import dsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEMA_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_req_i,
  input  logic              nxt_we_i,
  input  logic [ADDR_W-1:0] nxt_addr_i,
  input  logic [SEMA_W-1:0] sema_next_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              exe_req_o,
  output logic [WORD_W-1:0] exe_cmd_o,
  output logic [WORD_W-1:0] exe_buf_o,
  input  logic              exe_ack_i,
  output logic              complete_o,
  output logic              dec_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  seq_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] nxt_q;
  logic [WORD_W-1:0] word_q [DESC_WORDS];
  logic              chain;

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[g] <= '0;
      else if (st_q == ST_FETCH && mem_valid_i && !clr_i && idx_q == IDX_W'(g))
        word_q[g] <= mem_rdata_i;
    end
  end

  assign chain      = word_q[W_CMD][CHAIN_BIT];
  assign complete_o = (st_q == ST_EXEC) && exe_ack_i && !clr_i;
  assign dec_o      = complete_o && word_q[W_CMD][DEC_BIT];
  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_FETCH);
  assign mem_addr_o = nxt_q + ADDR_W'({idx_q, 2'b00});
  assign exe_req_o  = (st_q == ST_EXEC);
  assign exe_cmd_o  = word_q[W_CMD];
  assign exe_buf_o  = word_q[W_BUF];
  assign nxt_o      = nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      nxt_q <= '0;
    end else if (clr_i) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (nxt_we_i) nxt_q <= nxt_addr_i;
          if (start_req_i) begin
            st_q  <= ST_FETCH;
            idx_q <= '0;
          end
        end
        ST_FETCH: begin
          if (mem_valid_i) begin
            if (idx_q == IDX_LAST) begin
              st_q  <= ST_EXEC;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_EXEC: begin
          if (exe_ack_i) begin
            if (chain) nxt_q <= word_q[W_NEXT][ADDR_W-1:0];
            st_q <= (chain && sema_next_i != '0) ? ST_FETCH : ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_fetch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i && !clr_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_exec_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exe_req_o && !exe_ack_i && !clr_i) |=> (exe_req_o && $stable(exe_buf_o)));

  p_nxt_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH) |=> (nxt_q == $past(nxt_q)));
endmodule

// File: rtl/dsc_chain_seq.sv
module dsc_chain_seq #(
  parameter int ADDR_W = 32,
  parameter int SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_rst_i,
  input  logic              nxt_we_i,
  input  logic [ADDR_W-1:0] nxt_addr_i,
  input  logic              sema_we_i,
  input  logic [SEMA_W-1:0] sema_val_i,
  output logic [SEMA_W-1:0] sema_o,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic              busy_o,
  output logic              cmd_done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              exe_req_o,
  output logic [31:0]       exe_cmd_o,
  output logic [31:0]       exe_buf_o,
  input  logic              exe_ack_i
);
  localparam int WORD_W = 32;

  logic              complete;
  logic              dec;
  logic              start_req;
  logic [SEMA_W-1:0] sema_next;
  logic              done_q;

  assign start_req = sema_we_i && (sema_val_i != '0);

  dsc_sema #(.SEMA_W(SEMA_W)) u_sema (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (chan_rst_i),
    .add_i      (sema_we_i),
    .add_val_i  (sema_val_i),
    .dec_i      (dec),
    .cnt_o      (sema_o),
    .cnt_next_o (sema_next)
  );

  dsc_fetch #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W), .WORD_W(WORD_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (chan_rst_i),
    .start_req_i (start_req),
    .nxt_we_i    (nxt_we_i),
    .nxt_addr_i  (nxt_addr_i),
    .sema_next_i (sema_next),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .exe_req_o   (exe_req_o),
    .exe_cmd_o   (exe_cmd_o),
    .exe_buf_o   (exe_buf_o),
    .exe_ack_i   (exe_ack_i),
    .complete_o  (complete),
    .dec_o       (dec),
    .busy_o      (busy_o),
    .nxt_o       (nxt_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= complete;
  end
  assign cmd_done_o = done_q;

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o);

  p_stop_at_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_o && sema_o == '0) |-> !busy_o);

  p_chan_rst_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> (!busy_o && sema_o == '0 && !mem_req_o && !exe_req_o && !cmd_done_o));
endmodule

// File: tb/dsc_chain_seq_tb.sv
module dsc_chain_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SEMA_W = 8;

  typedef struct packed {
    logic [31:0] start;
    logic [7:0]  sema;
    logic [7:0]  n_done;
    logic [7:0]  sema_end;
    logic [31:0] nxt_end;
    logic [31:0] buf_end;
  } vec_t;

  // R7 R8 R9 R6 scenarios over the descriptor set built below
  localparam vec_t VEC [7] = '{
    '{32'h00, 8'd3, 8'd3, 8'd0, 32'h20, 32'hB000_0002},
    '{32'h00, 8'd1, 8'd1, 8'd0, 32'h10, 32'hB000_0000},
    '{32'h00, 8'd5, 8'd3, 8'd2, 32'h20, 32'hB000_0002},
    '{32'h40, 8'd1, 8'd2, 8'd0, 32'h60, 32'hB000_0005},
    '{32'h60, 8'd1, 8'd1, 8'd0, 32'h60, 32'hB000_0006},
    '{32'h70, 8'd4, 8'd4, 8'd0, 32'h70, 32'hB000_0007},
    '{32'h80, 8'd2, 8'd1, 8'd2, 32'h80, 32'hB000_0008}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chan_rst = 1'b0;
  logic              nxt_we = 1'b0;
  logic [ADDR_W-1:0] nxt_addr = '0;
  logic              sema_we = 1'b0;
  logic [SEMA_W-1:0] sema_val = '0;
  logic [SEMA_W-1:0] sema;
  logic [ADDR_W-1:0] nxt_o;
  logic              busy, cmd_done, mem_req, exe_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_valid = 1'b0;
  logic [31:0]       mem_rdata = '0;
  logic [31:0]       exe_cmd, exe_buf;
  logic              exe_ack = 1'b0;

  logic [31:0] mem [64];
  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, rd_cnt = 0;
  logic [31:0] last_buf = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsc_chain_seq #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_rst_i(chan_rst),
    .nxt_we_i(nxt_we), .nxt_addr_i(nxt_addr),
    .sema_we_i(sema_we), .sema_val_i(sema_val),
    .sema_o(sema), .nxt_addr_o(nxt_o), .busy_o(busy), .cmd_done_o(cmd_done),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_rdata_i(mem_rdata), .exe_req_o(exe_req), .exe_cmd_o(exe_cmd),
    .exe_buf_o(exe_buf), .exe_ack_i(exe_ack)
  );

  // memory and peripheral stubs, one cycle latency each
  always @(posedge clk) begin
    mem_valid <= mem_req && !mem_valid;
    mem_rdata <= mem[mem_addr[7:2]];
    exe_ack   <= exe_req && !exe_ack;
    if (cmd_done) done_cnt <= done_cnt + 1;
    if (mem_req && mem_valid) rd_cnt <= rd_cnt + 1;
    if (exe_req && exe_ack) last_buf <= exe_buf;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_desc(int k, logic [31:0] nxt, logic [31:0] cmd);
    mem[4*k]   = nxt;
    mem[4*k+1] = cmd;
    mem[4*k+2] = 32'hB000_0000 | k;
    mem[4*k+3] = '0;
  endtask

  task automatic pulse_chan_rst();
    @(negedge clk) chan_rst = 1'b1;
    @(negedge clk) chan_rst = 1'b0;
  endtask

  task automatic write_nxt(logic [31:0] a);
    @(negedge clk) begin nxt_we = 1'b1; nxt_addr = a; end
    @(negedge clk) nxt_we = 1'b0;
  endtask

  task automatic write_sema(logic [7:0] v);
    @(negedge clk) begin sema_we = 1'b1; sema_val = v; end
    @(negedge clk) sema_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int d0, r0;
    logic [7:0] s;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    set_desc(0, 32'h10, 32'h44);
    set_desc(1, 32'h20, 32'h44);
    set_desc(2, 32'h30, 32'h40);
    set_desc(4, 32'h50, 32'h04);
    set_desc(5, 32'h60, 32'h44);
    set_desc(6, 32'h70, 32'h40);
    set_desc(7, 32'h70, 32'h44);
    set_desc(8, 32'h90, 32'h00);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 sema", {24'd0, sema}, 0);
    check("R1 nxt", nxt_o, 0);
    check("R1 reqs", {29'd0, mem_req, exe_req, cmd_done}, 0);

    // R3 zero write does not start
    write_sema(8'd0);
    check("R3 zero write busy", {31'd0, busy}, 0);

    for (int v = 0; v < 7; v++) begin
      pulse_chan_rst();
      write_nxt(VEC[v].start);
      d0 = done_cnt; r0 = rd_cnt;
      @(negedge clk) begin sema_we = 1'b1; sema_val = VEC[v].sema; end
      @(negedge clk) sema_we = 1'b0;
      check("R3 starts", {31'd0, busy}, 1);
      wait_idle();
      check("R7 R8 R9 done count", done_cnt - d0, VEC[v].n_done);
      check("R4 reads", rd_cnt - r0, 3 * VEC[v].n_done);
      check("R2 R6 sema end", {24'd0, sema}, {24'd0, VEC[v].sema_end});
      check("R7 nxt end", nxt_o, VEC[v].nxt_end);
      check("R5 last buf", last_buf, VEC[v].buf_end);
    end

    // R13 restart from stored address
    pulse_chan_rst();
    write_nxt(32'h00);
    write_sema(8'd1);
    wait_idle();
    check("R13 paused nxt", nxt_o, 32'h10);
    d0 = done_cnt;
    write_sema(8'd2);
    wait_idle();
    check("R13 restart done", done_cnt - d0, 2);
    check("R13 restart buf", last_buf, 32'hB000_0002);

    // R10 top-up while busy
    pulse_chan_rst();
    write_nxt(32'h70);
    d0 = done_cnt;
    write_sema(8'd2);
    for (int i = 0; i < 200 && !cmd_done; i++) @(negedge clk);
    s = sema;
    sema_we = 1'b1; sema_val = 8'd3;
    @(negedge clk) sema_we = 1'b0;
    check("R10 R2 topup add", {24'd0, sema}, {24'd0, s + 8'd3});
    wait_idle();
    check("R10 topup done", done_cnt - d0, 5);

    // R10 write coinciding with decrement
    pulse_chan_rst();
    d0 = done_cnt;
    write_sema(8'd3);
    for (int i = 0; i < 200 && !exe_ack; i++) @(negedge clk);
    s = sema;
    sema_we = 1'b1; sema_val = 8'd2;
    @(negedge clk) sema_we = 1'b0;
    check("R10 same cycle", {24'd0, sema}, {24'd0, s + 8'd1});
    wait_idle();
    check("R10 same cycle done", done_cnt - d0, 5);

    // R11 address write while busy ignored
    pulse_chan_rst();
    d0 = done_cnt;
    write_sema(8'd3);
    write_nxt(32'h300);
    wait_idle();
    check("R11 nxt kept", nxt_o, 32'h70);
    check("R11 done", done_cnt - d0, 3);

    // R12 channel reset overrides a simultaneous write
    write_sema(8'd50);
    repeat (20) @(negedge clk);
    chan_rst = 1'b1; sema_we = 1'b1; sema_val = 8'd5;
    @(negedge clk) begin chan_rst = 1'b0; sema_we = 1'b0; end
    check("R12 busy", {31'd0, busy}, 0);
    check("R12 sema", {24'd0, sema}, 0);
    check("R12 reqs", {30'd0, mem_req, exe_req}, 0);
    d0 = done_cnt;
    repeat (20) @(negedge clk);
    check("R12 no more done", done_cnt - d0, 0);
    check("R12 still idle", {31'd0, busy}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule